// File: doc/BRIEF.md
# Sprite Priority Mixer

This block picks, for every display pixel, which of three kinds of source is visible: the border, one of a set of hardware sprites, or the main playfield. It takes the current beam coordinates, a border-active flag and the playfield's 4-bit palette index. From these it produces one palette index, a tag naming the winning kind of source and, when a sprite wins, that sprite's number. Turning the index into a colour is left to a later stage.

Each sprite has a signed X and Y position, a magnification byte and a square image held in local registers. The image stores one 4-bit pixel per entry. A simple write port loads positions, magnification bytes and single image pixels. The X and Y scale factors are set separately. A pixel whose value is zero is transparent, so whatever lies below it shows through. The result is registered, so it appears one clock after the beam inputs.

Top module: `sprite_prio_mixer`

## Requirements
- R1: While `borderOn` is high, the next output has `pixSrc` = 2 (border), `pixIdx` = 0 and `sprNum` = 0, whatever the sprites and the playfield hold.
- R2: When several sprites have an opaque pixel at the beam, the one with the lowest number wins.
- R3: A sprite pixel value of 0 is transparent: the next lower-priority source is shown, and a sprite win never outputs index 0.
- R4: When the border is off and no sprite has an opaque pixel, the output is `pixSrc` = 0 (playfield) with `pixIdx` equal to `pfIdx`. The value of `pfIdx` is used as it is, including 0.
- R5: An image write (`wrKind` = 0) stores `wrData[3:0]` as the pixel at `wrPix` = row*16 + column. All higher data bits are ignored.
- R6: A magnification write (`wrKind` = 3) uses `wrData[3:2]` as the X code and `wrData[1:0]` as the Y code. All higher data bits are ignored. Position writes use `wrKind` = 1 for X and 2 for Y.
- R7: Codes 01, 10 and 11 give factors 1, 2 and 4. A sprite covers 16*factor pixels on each axis. The source column (or row) is the offset from the sprite position divided by that axis's factor.
- R8: If either magnification code is 00, the sprite contributes nothing. After reset, every sprite's codes are 00.
- R9: Sprite positions are 16-bit two's-complement values, so a sprite may start left of or above pixel 0 and is clipped there.
- R10: The output registers change only on the rising clock edge and reflect the inputs present one cycle earlier. Reset gives `pixSrc` = 0, `pixIdx` = 0 and `sprNum` = 0.
- R11: `sprNum` carries the winning sprite's number when `pixSrc` = 1 (sprite), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Write target: 0 image pixel, 1 X position, 2 Y position, 3 magnification |
| wrSpr | input | 4 | Sprite number addressed by the write |
| wrPix | input | 8 | Image pixel address, row*16 + column |
| wrData | input | 16 | Write data |
| beamX | input | 16 | Current beam column |
| beamY | input | 16 | Current beam line |
| borderOn | input | 1 | Beam is in the border |
| pfIdx | input | 4 | Playfield palette index |
| pixIdx | output | 4 | Winning palette index |
| pixSrc | output | 2 | Winning source: 0 playfield, 1 sprite, 2 border |
| sprNum | output | 4 | Winning sprite number, 0 if no sprite wins |

## Verification
The bench builds the block with its default parameters: sixteen sprites, 16x16 images, 4-bit indices and 16-bit coordinates. With these values the full priority chain from sprite 0 to sprite 15 can be tested. The x4 footprint edge at offsets 63 and 64 falls inside the coordinate range, and negative positions wrap through the sign bit. Random scenes place sprites near the beam with mixed magnification codes and sparse images. Directed cases cover the limits of each factor, clipping at the top-left corner and overlapping sprites.

// File: rtl/sprite_mix_pkg.sv
package sprite_mix_pkg;

  typedef enum logic [1:0] {
    SRC_PF     = 2'd0,
    SRC_SPR    = 2'd1,
    SRC_BORDER = 2'd2
  } src_t;

  localparam logic [1:0] KIND_IMG  = 2'd0;
  localparam logic [1:0] KIND_POSX = 2'd1;
  localparam logic [1:0] KIND_POSY = 2'd2;
  localparam logic [1:0] KIND_MAG  = 2'd3;

  typedef struct packed {
    logic img;
    logic posX;
    logic posY;
    logic mag;
  } wr_strobe_t;

endpackage

// File: rtl/sprite_mix_ctrl.sv
module sprite_mix_ctrl
  import sprite_mix_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrKind,
  output wr_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrKind)
        KIND_IMG:  strobe.img  = 1'b1;
        KIND_POSX: strobe.posX = 1'b1;
        KIND_POSY: strobe.posY = 1'b1;
        KIND_MAG:  strobe.mag  = 1'b1;
        default:   strobe      = '0;
      endcase
    end
  end

endmodule

// File: rtl/sprite_hit.sv
module sprite_hit #(
  parameter int SPR_DIM = 16,
  parameter int IDX_W   = 4,
  parameter int POS_W   = 16
) (
  input  logic [POS_W-1:0]               beamX,
  input  logic [POS_W-1:0]               beamY,
  input  logic [POS_W-1:0]               posX,
  input  logic [POS_W-1:0]               posY,
  input  logic [3:0]                     mag,
  input  logic [SPR_DIM*SPR_DIM*IDX_W-1:0] img,
  output logic                           hit,
  output logic [IDX_W-1:0]               pix
);

  localparam int LOG_DIM = $clog2(SPR_DIM);
  localparam int EXT_W   = POS_W + 2;

  function automatic logic [1:0] shiftOf(input logic [1:0] code);
    case (code)
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  logic signed [EXT_W-1:0] dx, dy;
  logic [EXT_W-1:0] ux, uy;
  logic [LOG_DIM-1:0] col, row;
  logic inX, inY, shown;

  always_comb begin
    dx    = $signed({2'b00, beamX}) - $signed({{2{posX[POS_W-1]}}, posX});
    dy    = $signed({2'b00, beamY}) - $signed({{2{posY[POS_W-1]}}, posY});
    ux    = $unsigned(dx) >> shiftOf(mag[3:2]);
    uy    = $unsigned(dy) >> shiftOf(mag[1:0]);
    inX   = !dx[EXT_W-1] && (ux < EXT_W'(SPR_DIM));
    inY   = !dy[EXT_W-1] && (uy < EXT_W'(SPR_DIM));
    col   = ux[LOG_DIM-1:0];
    row   = uy[LOG_DIM-1:0];
    pix   = img[{row, col}*IDX_W +: IDX_W];
    shown = (|mag[3:2]) && (|mag[1:0]);
    hit   = shown && inX && inY && (|pix);
  end

endmodule

// File: rtl/sprite_mix_dp.sv
module sprite_mix_dp
  import sprite_mix_pkg::*;
#(
  parameter int NUM_SPR    = 16,
  parameter int SPR_DIM    = 16,
  parameter int IDX_W      = 4,
  parameter int POS_W      = 16,
  parameter int SPR_ID_W   = 4,
  parameter int PIX_ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wr_strobe_t            strobe,
  input  logic [SPR_ID_W-1:0]   wrSpr,
  input  logic [PIX_ADDR_W-1:0] wrPix,
  input  logic [POS_W-1:0]      wrData,
  input  logic [POS_W-1:0]      beamX,
  input  logic [POS_W-1:0]      beamY,
  input  logic                  borderOn,
  input  logic [IDX_W-1:0]      pfIdx,
  output logic [IDX_W-1:0]      pixIdx,
  output logic [1:0]            pixSrc,
  output logic [SPR_ID_W-1:0]   sprNum
);

  localparam int IMG_W = SPR_DIM * SPR_DIM * IDX_W;

  logic [IMG_W-1:0] img  [NUM_SPR];
  logic [POS_W-1:0] posX [NUM_SPR];
  logic [POS_W-1:0] posY [NUM_SPR];
  logic [3:0]       mag  [NUM_SPR];

  logic [NUM_SPR-1:0] hitVec;
  logic [IDX_W-1:0]   hitPix [NUM_SPR];

  logic                anyHit;
  logic [SPR_ID_W-1:0] winNum;
  logic [IDX_W-1:0]    winPix;

  src_t                srcQ;
  logic [IDX_W-1:0]    idxQ;
  logic [SPR_ID_W-1:0] numQ;

  // Image store: no reset, a sprite stays hidden until its codes are set.
  always_ff @(posedge clk) begin
    if (strobe.img) img[wrSpr][wrPix*IDX_W +: IDX_W] <= wrData[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SPR; s++) begin
        posX[s] <= '0;
        posY[s] <= '0;
        mag[s]  <= '0;
      end
    end else begin
      if (strobe.posX) posX[wrSpr] <= wrData;
      if (strobe.posY) posY[wrSpr] <= wrData;
      if (strobe.mag)  mag[wrSpr]  <= wrData[3:0];
    end
  end

  for (genvar s = 0; s < NUM_SPR; s++) begin : g_spr
    sprite_hit #(
      .SPR_DIM(SPR_DIM),
      .IDX_W  (IDX_W),
      .POS_W  (POS_W)
    ) u_hit (
      .beamX(beamX),
      .beamY(beamY),
      .posX (posX[s]),
      .posY (posY[s]),
      .mag  (mag[s]),
      .img  (img[s]),
      .hit  (hitVec[s]),
      .pix  (hitPix[s])
    );

    AST_HIDDEN: assert property (@(posedge clk) disable iff (rst)
      (mag[s][3:2] == 2'b00 || mag[s][1:0] == 2'b00) |-> !hitVec[s])
      else $error("hidden sprite produced a hit"); // R8
  end

  // Scan from the weakest sprite up so the lowest number is written last.
  always_comb begin
    anyHit = 1'b0;
    winNum = '0;
    winPix = '0;
    for (int s = NUM_SPR - 1; s >= 0; s--) begin
      if (hitVec[s]) begin
        anyHit = 1'b1;
        winNum = SPR_ID_W'(s);
        winPix = hitPix[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ <= SRC_PF;
      idxQ <= '0;
      numQ <= '0;
    end else if (borderOn) begin
      srcQ <= SRC_BORDER;
      idxQ <= '0;
      numQ <= '0;
    end else if (anyHit) begin
      srcQ <= SRC_SPR;
      idxQ <= winPix;
      numQ <= winNum;
    end else begin
      srcQ <= SRC_PF;
      idxQ <= pfIdx;
      numQ <= '0;
    end
  end

  assign pixIdx = idxQ;
  assign pixSrc = srcQ;
  assign sprNum = numQ;

  AST_BORDER_WINS: assert property (@(posedge clk) disable iff (rst)
    borderOn |=> (pixSrc == SRC_BORDER && pixIdx == '0 && sprNum == '0))
    else $error("border did not win"); // R1

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (rst)
    (!borderOn && hitVec[0]) |=> (pixSrc == SRC_SPR && sprNum == '0 && pixIdx == $past(hitPix[0])))
    else $error("sprite 0 did not win"); // R2

  AST_SPR_OPAQUE: assert property (@(posedge clk) disable iff (rst)
    (pixSrc == SRC_SPR) |-> (pixIdx != '0))
    else $error("transparent sprite pixel shown"); // R3

  AST_PF_LAST: assert property (@(posedge clk) disable iff (rst)
    (!borderOn && hitVec == '0) |=> (pixSrc == SRC_PF && pixIdx == $past(pfIdx)))
    else $error("playfield not passed through"); // R4

  AST_NUM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pixSrc != SRC_SPR) |-> (sprNum == '0))
    else $error("sprite number set without sprite win"); // R11

endmodule

// File: rtl/sprite_prio_mixer.sv
module sprite_prio_mixer
  import sprite_mix_pkg::*;
#(
  parameter int NUM_SPR = 16,
  parameter int SPR_DIM = 16,
  parameter int IDX_W   = 4,
  parameter int POS_W   = 16,
  localparam int SPR_ID_W   = $clog2(NUM_SPR),
  localparam int PIX_ADDR_W = 2 * $clog2(SPR_DIM)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [1:0]            wrKind,
  input  logic [SPR_ID_W-1:0]   wrSpr,
  input  logic [PIX_ADDR_W-1:0] wrPix,
  input  logic [POS_W-1:0]      wrData,
  input  logic [POS_W-1:0]      beamX,
  input  logic [POS_W-1:0]      beamY,
  input  logic                  borderOn,
  input  logic [IDX_W-1:0]      pfIdx,
  output logic [IDX_W-1:0]      pixIdx,
  output logic [1:0]            pixSrc,
  output logic [SPR_ID_W-1:0]   sprNum
);

  wr_strobe_t strobe;

  sprite_mix_ctrl u_ctrl (
    .wrEn  (wrEn),
    .wrKind(wrKind),
    .strobe(strobe)
  );

  sprite_mix_dp #(
    .NUM_SPR   (NUM_SPR),
    .SPR_DIM   (SPR_DIM),
    .IDX_W     (IDX_W),
    .POS_W     (POS_W),
    .SPR_ID_W  (SPR_ID_W),
    .PIX_ADDR_W(PIX_ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wrSpr   (wrSpr),
    .wrPix   (wrPix),
    .wrData  (wrData),
    .beamX   (beamX),
    .beamY   (beamY),
    .borderOn(borderOn),
    .pfIdx   (pfIdx),
    .pixIdx  (pixIdx),
    .pixSrc  (pixSrc),
    .sprNum  (sprNum)
  );

endmodule

// File: tb/sim_sprite_prio_mixer.sv
module sim_sprite_prio_mixer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = '0;
  logic [3:0]  wrSpr = '0;
  logic [7:0]  wrPix = '0;
  logic [15:0] wrData = '0;
  logic [15:0] beamX = '0;
  logic [15:0] beamY = '0;
  logic        borderOn = 1'b0;
  logic [3:0]  pfIdx = '0;
  logic [3:0]  pixIdx;
  logic [1:0]  pixSrc;
  logic [3:0]  sprNum;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // Model state written from the requirements.
  logic [3:0]    mMag [16];
  logic [15:0]   mX   [16];
  logic [15:0]   mY   [16];
  logic [1023:0] mImg [16];

  sprite_prio_mixer u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrKind(wrKind), .wrSpr(wrSpr),
    .wrPix(wrPix), .wrData(wrData), .beamX(beamX), .beamY(beamY),
    .borderOn(borderOn), .pfIdx(pfIdx), .pixIdx(pixIdx), .pixSrc(pixSrc),
    .sprNum(sprNum)
  );

  always #5 clk = ~clk;

  // Result packing: {src[1:0], num[3:0], idx[3:0]}
  function automatic logic [9:0] expectPix(int bx, int by, logic bord, logic [3:0] pf);
    if (bord) return {2'd2, 4'd0, 4'd0};
    for (int s = 0; s < 16; s++) begin
      int fx, fy, dx, dy, col, row;
      logic [3:0] p;
      if (mMag[s][3:2] == 2'b00 || mMag[s][1:0] == 2'b00) continue;
      fx = 1 << (int'(mMag[s][3:2]) - 1);
      fy = 1 << (int'(mMag[s][1:0]) - 1);
      dx = bx - int'($signed(mX[s]));
      dy = by - int'($signed(mY[s]));
      if (dx < 0 || dy < 0 || dx >= 16 * fx || dy >= 16 * fy) continue;
      col = dx / fx;
      row = dy / fy;
      p = mImg[s][(row * 16 + col) * 4 +: 4];
      if (p != 4'd0) return {2'd1, 4'(s), p};
    end
    return {2'd0, 4'd0, pf};
  endfunction

  task automatic check(input logic [9:0] exp, input string tag);
    nChecks++;
    if ({pixSrc, sprNum, pixIdx} !== exp) begin
      nErrors++;
      $display("FAIL %s: got src=%0d num=%0d idx=%0d expected src=%0d num=%0d idx=%0d",
               tag, pixSrc, sprNum, pixIdx, exp[9:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic wr(input logic [1:0] k, input int s, input int p, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrKind = k; wrSpr = 4'(s); wrPix = 8'(p); wrData = d;
    case (k)
      2'd0: mImg[s][p * 4 +: 4] = d[3:0];
      2'd1: mX[s] = d;
      2'd2: mY[s] = d;
      default: mMag[s] = d[3:0];
    endcase
  endtask

  task automatic probe(input int bx, input int by, input logic bord, input logic [3:0] pf,
                       input string tag);
    logic [9:0] exp;
    @(negedge clk);
    wrEn = 1'b0;
    beamX = 16'(bx); beamY = 16'(by); borderOn = bord; pfIdx = pf;
    exp = expectPix(bx, by, bord, pf);
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  task automatic place(input int s, input int x, input int y, input logic [15:0] m);
    wr(2'd1, s, 0, 16'(x));
    wr(2'd2, s, 0, 16'(y));
    wr(2'd3, s, 0, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 16; s++) begin
      mMag[s] = '0; mX[s] = '0; mY[s] = '0; mImg[s] = '0;
    end

    // R10 reset state
    repeat (3) @(posedge clk);
    #1;
    check({2'd0, 4'd0, 4'd0}, "R10 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R4 / R8: all sprites hidden after reset, playfield passes, index 0 included
    probe(5, 5, 1'b0, 4'd9, "R4 playfield pass");
    probe(40, 3, 1'b0, 4'd0, "R4 playfield index 0");

    // Sprite 3 image: nonzero pattern, pixel 0 written 0xF0, pixel (1,1) written 0xA7
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        wr(2'd0, 3, r * 16 + c, 16'(((r + c) % 15) + 1));
    wr(2'd0, 3, 0, 16'h00F0);
    wr(2'd0, 3, 17, 16'h12A7);
    place(3, 10, 20, 16'h0005);
    probe(10, 20, 1'b0, 4'd6, "R5 upper bits ignored gives transparent");
    probe(11, 21, 1'b0, 4'd6, "R5 low nibble stored R11 number");
    probe(12, 20, 1'b0, 4'd6, "R3 opaque pixel shown");

    // R1 border over sprite
    probe(11, 21, 1'b1, 4'd6, "R1 border beats sprite");

    // R6 upper magnification bits ignored
    wr(2'd3, 3, 0, 16'hABF5);
    probe(25, 20, 1'b0, 4'd2, "R6 x1 right edge inside");
    probe(26, 20, 1'b0, 4'd2, "R6 x1 right edge outside");

    // R7 factors
    wr(2'd3, 3, 0, 16'h000F);
    probe(10 + 63, 20 + 63, 1'b0, 4'd3, "R7 x4 last pixel");
    probe(10 + 64, 20, 1'b0, 4'd3, "R7 x4 past edge");
    probe(10 + 22, 20 + 11, 1'b0, 4'd3, "R7 x4 interior");
    wr(2'd3, 3, 0, 16'h000A);
    probe(10 + 7, 20 + 8, 1'b0, 4'd3, "R7 x2 interior");
    probe(10 + 31, 20 + 31, 1'b0, 4'd3, "R7 x2 last pixel");
    probe(10 + 32, 20, 1'b0, 4'd3, "R7 x2 past edge");
    wr(2'd3, 3, 0, 16'h000D);
    probe(10 + 7, 20 + 15, 1'b0, 4'd3, "R7 x4 by y1");
    probe(10, 20 + 16, 1'b0, 4'd3, "R7 y1 past edge");

    // R8 hidden codes
    wr(2'd3, 3, 0, 16'h000C);
    probe(11, 21, 1'b0, 4'd4, "R8 y code 00 hides");
    wr(2'd3, 3, 0, 16'h0003);
    probe(11, 21, 1'b0, 4'd4, "R8 x code 00 hides");
    wr(2'd3, 3, 0, 16'h0005);

    // R2 / R3 overlap ordering
    for (int p = 0; p < 256; p++) wr(2'd0, 5, p, 16'h000E);
    place(5, 10, 20, 16'h0005);
    probe(11, 21, 1'b0, 4'd4, "R2 sprite 3 beats sprite 5");
    probe(10, 20, 1'b0, 4'd4, "R3 transparent lets sprite 5 through");
    for (int p = 0; p < 256; p++) wr(2'd0, 0, p, 16'h0001);
    place(0, 5, 18, 16'h0005);
    probe(11, 21, 1'b0, 4'd4, "R2 sprite 0 beats all R11");

    // R9 negative positions
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        wr(2'd0, 15, r * 16 + c, 16'(((r * 3 + c) % 15) + 1));
    place(15, -8, -3, 16'h0005);
    probe(0, 0, 1'b0, 4'd7, "R9 clipped corner");
    probe(7, 12, 1'b0, 4'd7, "R9 clipped last pixel");
    probe(8, 0, 1'b0, 4'd7, "R9 past clipped edge x");
    probe(0, 13, 1'b0, 4'd7, "R9 past clipped edge y");

    // R10 output holds until the next rising edge
    probe(11, 21, 1'b0, 4'd4, "R10 setup");
    held = {pixSrc, sprNum, pixIdx};
    @(negedge clk);
    beamX = 16'd300; beamY = 16'd300; borderOn = 1'b1; pfIdx = 4'd9;
    #2;
    check(held, "R10 no change before edge");
    @(posedge clk);
    #1;
    check({2'd2, 4'd0, 4'd0}, "R10 change after edge");

    // Random scenes
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int s = 0; s < 16; s++) begin
        for (int p = 0; p < 256; p++) begin
          logic [3:0] v;
          v = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 16);
          wr(2'd0, s, p, {12'($urandom), v});
        end
        place(s, int'($urandom % 240) - 40, int'($urandom % 240) - 40,
              16'($urandom));
      end
      for (int n = 0; n < 400; n++) begin
        int s, bx, by;
        s = int'($urandom % 16);
        bx = int'($signed(mX[s])) + int'($urandom % 80) - 8;
        by = int'($signed(mY[s])) + int'($urandom % 80) - 8;
        if (bx < 0) bx = 0;
        if (by < 0) by = 0;
        probe(bx, by, ($urandom % 16) == 0, 4'($urandom), "R2/R3/R7 random scene");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule